// File: doc/BRIEF.md
# Literal and copy item encoder

This block is the decision and packing stage of a dictionary compressor. For every input position a front end presents one byte on a valid/taken stream. Along with it come the outcome of the hash table lookup and history comparison: a hit flag, the 12-bit table index that matched, and how many bytes beyond the first three also matched. The encoder turns each position into an item. A position with no hit becomes a one-byte literal. A hit becomes a two-byte copy item that stands for 3 to 18 input bytes. After a copy, the encoder silently consumes the input bytes that the copy already covers.

Items are collected into groups of at most 16. Each group carries a 16-bit control word that marks which items are copies. A group is offered whole on the output with its size and a last flag, and it is held there until the consumer takes it. A run starts with a go pulse and ends with a done pulse after the final group has been taken.

The controller has four states. ST_IDLE moves to ST_COLLECT on go. ST_COLLECT moves to ST_SEND either when the end-of-file beat is consumed, or when the group is full, no skip is pending and a new item beat is waiting. ST_SEND moves back to ST_COLLECT when a non-final group is taken, and to ST_FINISH when the final group is taken. ST_FINISH returns to ST_IDLE after one cycle.

Top module: `lzi_encoder`

## Requirements
- R1: An input beat without a hit becomes a literal item. Its 16-bit slot holds the byte in bits 7:0 and zero in bits 15:8, and its control bit is 0.
- R2: A copy item occupies its 16-bit slot as {extra length[3:0] in bits 15:12, table index in bits 11:0} and sets its control bit to 1. Item i of a group sits in out_items bits 16*i+15:16*i and in control bit i, so the first item is in the LSB.
- R3: After a copy with extra length E, the next E+2 accepted beats produce no item, whatever their hit inputs carry. The item after them comes from the following beat.
- R4: A group holds at most 16 items. A full group is offered with out_size 16 and out_last 0 once the next item beat is waiting, and out_size is never 0 or above 16 while out_valid is high.
- R5: A beat flagged in_eof always becomes a literal, even if hit is set, unless it falls inside a copy's skip span. Consuming it closes the current group, which is offered with its true size and out_last 1.
- R6: done is high for exactly one cycle, the cycle after the final group is taken. busy is high from the cycle after go through the done cycle and low after it.
- R7: go is ignored while busy is high. A go pulse mid-run neither restarts the run nor changes the mode.
- R8: With mode 1 latched at go, every beat becomes a literal and hit is ignored. With mode 0, hits produce copies.
- R9: While out_valid is high and out_taken is low, out_valid, out_size, out_ctrl, out_last and out_items stay unchanged, and in_taken is low.
- R10: After reset, busy, done, out_valid and in_taken are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, accepted only when idle |
| mode | input | 1 | 1 = literal-only, 0 = normal; latched at go |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |
| in_byte | input | 8 | Byte at the current input position |
| in_valid | input | 1 | Input beat valid |
| in_taken | output | 1 | Encoder accepts the beat this cycle |
| in_eof | input | 1 | Current beat is the last byte of the file |
| hit | input | 1 | Table row occupied and three bytes match |
| hit_index | input | 12 | Table index of the match |
| hit_extra | input | 4 | Matching bytes beyond the first three (0..15) |
| out_valid | output | 1 | A group is offered |
| out_taken | input | 1 | Consumer takes the offered group |
| out_last | output | 1 | Offered group is the final one |
| out_size | output | 5 | Number of items in the offered group |
| out_ctrl | output | 16 | Control word, bit i = 1 when item i is a copy |
| out_items | output | 256 | Sixteen 16-bit item slots |

## Verification
The bench checks skip spans at both ends of the extra-length range. An encoder that miscounts the advance would emit a spurious item from a covered byte, or would swallow the literal after the copy. A group with copies in its first and sixteenth slots, followed by more items, checks the LSB-first control order and the full-group handoff. A wrong boundary here would split the group at 15, or drop or overwrite the seventeenth item. Three further corners each expose a specific fault. An end-of-file beat that carries a hit would become a copy if the hit were not overridden. An end-of-file beat inside a skip span would leave the run hanging. A go pulse in mid-run would restart the run or flip the mode. A stalled consumer also checks that the group stays frozen, since a faulty encoder would let it change or take input behind it.

// File: rtl/lzi_pkg.sv
package lzi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_SEND    = 2'd2,
        ST_FINISH  = 2'd3
    } lzi_state_t;
endpackage

// File: rtl/lzi_item_decider.sv
module lzi_item_decider #(
    parameter int IDX_W  = 12,
    parameter int EXT_W  = 4,
    parameter int ITEM_W = IDX_W + EXT_W,
    parameter int SKIP_W = EXT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fire,
    input  logic [7:0]        in_byte,
    input  logic              in_eof,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_index,
    input  logic [EXT_W-1:0]  hit_extra,
    input  logic              literal_only,
    output logic              item_push,
    output logic              item_copy,
    output logic [ITEM_W-1:0] item_word,
    output logic              skip_idle
);
    logic [SKIP_W-1:0] skip_q;

    assign skip_idle = (skip_q == '0);
    assign item_push = fire && skip_idle;
    // end-of-file beat and literal-only mode force a literal (R5, R8)
    assign item_copy = hit && !in_eof && !literal_only;

    always_comb begin
        if (item_copy)
            item_word = {hit_extra, hit_index};
        else
            item_word = {{(ITEM_W-8){1'b0}}, in_byte};
    end

    // bytes still covered by the last copy (R3)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            skip_q <= '0;
        else if (clear)
            skip_q <= '0;
        else if (fire) begin
            if (!skip_idle)
                skip_q <= skip_q - SKIP_W'(1);
            else if (item_copy)
                skip_q <= SKIP_W'(hit_extra) + SKIP_W'(2);
        end
    end

    // a consumed beat during a skip span must never yield an item (R3)
    assert_skip_no_item_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !skip_idle) |-> !item_push);
endmodule

// File: rtl/lzi_group_buffer.sv
module lzi_group_buffer #(
    parameter int GRP_N  = 16,
    parameter int ITEM_W = 16,
    parameter int CNT_W  = $clog2(GRP_N + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    push,
    input  logic                    push_copy,
    input  logic [ITEM_W-1:0]       push_word,
    output logic [GRP_N-1:0]        ctrl,
    output logic [GRP_N*ITEM_W-1:0] items,
    output logic [CNT_W-1:0]        count,
    output logic                    full
);
    assign full = (count == CNT_W'(GRP_N));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (push)
            count <= count + CNT_W'(1);
    end

    for (genvar g = 0; g < GRP_N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                items[g*ITEM_W +: ITEM_W] <= '0;
                ctrl[g]                   <= 1'b0;
            end else if (clear) begin
                items[g*ITEM_W +: ITEM_W] <= '0;
                ctrl[g]                   <= 1'b0;
            end else if (push && count == CNT_W'(g)) begin
                items[g*ITEM_W +: ITEM_W] <= push_word;
                ctrl[g]                   <= push_copy;
            end
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // control bits above the fill level stay clear (R2)
    assert_ctrl_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl >> count) == '0);
endmodule

// File: rtl/lzi_encoder.sv
module lzi_encoder #(
    parameter int IDX_W = 12,
    parameter int EXT_W = 4,
    parameter int GRP_N = 16,
    localparam int ITEM_W = IDX_W + EXT_W,
    localparam int SIZE_W = $clog2(GRP_N + 1),
    localparam int SKIP_W = EXT_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic                    mode,
    output logic                    busy,
    output logic                    done,
    input  logic [7:0]              in_byte,
    input  logic                    in_valid,
    output logic                    in_taken,
    input  logic                    in_eof,
    input  logic                    hit,
    input  logic [IDX_W-1:0]        hit_index,
    input  logic [EXT_W-1:0]        hit_extra,
    output logic                    out_valid,
    input  logic                    out_taken,
    output logic                    out_last,
    output logic [SIZE_W-1:0]       out_size,
    output logic [GRP_N-1:0]        out_ctrl,
    output logic [GRP_N*ITEM_W-1:0] out_items
);
    import lzi_pkg::*;

    lzi_state_t state_q, state_d;
    logic       mode_q, last_q;
    logic       start, fire, grp_clear;
    logic       item_push, item_copy, skip_idle, grp_full;
    logic [ITEM_W-1:0] item_word;

    assign start     = (state_q == ST_IDLE) && go;
    assign fire      = in_valid && in_taken;
    assign grp_clear = start || (state_q == ST_SEND && out_taken);

    lzi_item_decider #(
        .IDX_W(IDX_W), .EXT_W(EXT_W), .ITEM_W(ITEM_W), .SKIP_W(SKIP_W)
    ) u_decider (
        .clk(clk), .rst_n(rst_n), .clear(start), .fire(fire),
        .in_byte(in_byte), .in_eof(in_eof), .hit(hit),
        .hit_index(hit_index), .hit_extra(hit_extra),
        .literal_only(mode_q),
        .item_push(item_push), .item_copy(item_copy),
        .item_word(item_word), .skip_idle(skip_idle)
    );

    lzi_group_buffer #(
        .GRP_N(GRP_N), .ITEM_W(ITEM_W), .CNT_W(SIZE_W)
    ) u_group (
        .clk(clk), .rst_n(rst_n), .clear(grp_clear),
        .push(item_push), .push_copy(item_copy), .push_word(item_word),
        .ctrl(out_ctrl), .items(out_items), .count(out_size), .full(grp_full)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                mode_q <= mode;
                last_q <= 1'b0;
            end else if (fire && in_eof) begin
                last_q <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (go) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (fire && in_eof)
                    state_d = ST_SEND;
                else if (grp_full && skip_idle && in_valid)
                    state_d = ST_SEND;
            end
            ST_SEND:    if (out_taken) state_d = last_q ? ST_FINISH : ST_COLLECT;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        out_valid = (state_q == ST_SEND);
        out_last  = last_q;
        in_taken  = (state_q == ST_COLLECT) && !(grp_full && skip_idle);
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_taken) |=> (out_valid && $stable(out_size) &&
        $stable(out_ctrl) && $stable(out_last) && $stable(out_items)));
    assert_no_input_while_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_taken);
    assert_size_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_size != '0 && out_size <= SIZE_W'(GRP_N)));
    assert_done_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_taken && out_last));
    assert_busy_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/lzi_encoder_test.sv
module lzi_encoder_test;
    localparam int GRP_N = 16;
    localparam int IW    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0, mode = 1'b0;
    logic        busy, done;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0, in_eof = 1'b0, hit = 1'b0;
    logic        in_taken;
    logic [11:0] hit_index = '0;
    logic [3:0]  hit_extra = '0;
    logic        out_valid, out_last;
    logic        out_taken = 1'b1;
    logic [4:0]  out_size;
    logic [15:0] out_ctrl;
    logic [GRP_N*IW-1:0] out_items;

    int n_chk = 0, n_fail = 0, cyc = 0, n_grp = 0, xfer_cyc = 0;
    logic [15:0]         g_ctrl  [8];
    logic [4:0]          g_size  [8];
    logic                g_last  [8];
    logic [GRP_N*IW-1:0] g_items [8];

    lzi_encoder uut (
        .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .busy(busy), .done(done),
        .in_byte(in_byte), .in_valid(in_valid), .in_taken(in_taken), .in_eof(in_eof),
        .hit(hit), .hit_index(hit_index), .hit_extra(hit_extra),
        .out_valid(out_valid), .out_taken(out_taken), .out_last(out_last),
        .out_size(out_size), .out_ctrl(out_ctrl), .out_items(out_items)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // group monitor: a group transfers at the edge after a negedge with valid && taken
    always @(negedge clk) begin
        if (out_valid && out_taken && n_grp < 8) begin
            g_ctrl[n_grp]  <= out_ctrl;
            g_size[n_grp]  <= out_size;
            g_last[n_grp]  <= out_last;
            g_items[n_grp] <= out_items;
            n_grp          <= n_grp + 1;
            xfer_cyc       <= cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic m);
        n_grp = 0;
        go = 1'b1; mode = m;
        @(negedge clk);
        go = 1'b0; mode = 1'b0;
    endtask

    task automatic put(input logic [7:0] b, input logic h, input logic [11:0] idx,
                       input logic [3:0] ext, input logic eof);
        in_byte = b; hit = h; hit_index = idx; hit_extra = ext; in_eof = eof;
        in_valid = 1'b1;
        while (!in_taken) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; hit = 1'b0; in_eof = 1'b0;
    endtask

    task automatic lit(input logic [7:0] b);
        put(b, 1'b0, '0, '0, 1'b0);
    endtask

    // covered bytes carry junk hits that must be ignored
    task automatic skips(input int n);
        for (int i = 0; i < n; i++) put(8'hEE, 1'b1, 12'hFFF, 4'hF, 1'b0);
    endtask

    task automatic finish_run(input string req);
        while (!done) @(negedge clk);
        chk(cyc == xfer_cyc + 1, "R6 done one cycle after last take", cyc, xfer_cyc + 1);
        chk(busy == 1'b1, "R6 busy during done", busy, 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R6 done and busy low after", {done, busy}, 0);
        chk(n_grp >= 1, req, n_grp, 1);
    endtask

    task automatic chk_grp(input int g, input logic [4:0] sz, input logic [15:0] ct,
                           input logic lst, input string req);
        chk(g_size[g] == sz, req, g_size[g], sz);
        chk(g_ctrl[g] == ct, req, g_ctrl[g], ct);
        chk(g_last[g] == lst, req, g_last[g], lst);
    endtask

    task automatic chk_item(input int g, input int i, input logic [15:0] v, input string req);
        chk(g_items[g][IW*i +: IW] == v, req, g_items[g][IW*i +: IW], v);
    endtask

    task automatic t_reset;
        chk({busy, done, out_valid, in_taken} == 4'b0, "R10 reset outputs",
            {busy, done, out_valid, in_taken}, 0);
    endtask

    task automatic t_literals;
        start(1'b0);
        chk(busy == 1'b1, "R6 busy after go", busy, 1);
        lit(8'h10); lit(8'h21); lit(8'h32); lit(8'h43);
        put(8'h54, 1'b0, '0, '0, 1'b1);
        finish_run("R1 literal run");
        chk(n_grp == 1, "R5 one group", n_grp, 1);
        chk_grp(0, 5'd5, 16'h0000, 1'b1, "R1 R5 literal group");
        chk_item(0, 0, 16'h0010, "R1 literal slot 0");
        chk_item(0, 4, 16'h0054, "R1 literal slot 4");
    endtask

    task automatic t_copy;
        start(1'b0);
        lit(8'h41);
        put(8'h99, 1'b1, 12'h123, 4'd2, 1'b0);
        skips(4);
        put(8'h42, 1'b0, '0, '0, 1'b1);
        finish_run("R3 copy run");
        chk_grp(0, 5'd3, 16'h0002, 1'b1, "R2 R3 copy group");
        chk_item(0, 1, 16'h2123, "R2 copy encoding");
        chk_item(0, 2, 16'h0042, "R3 literal after skip span");
    endtask

    task automatic t_copy_extremes;
        start(1'b0);
        put(8'h01, 1'b1, 12'hABC, 4'd0, 1'b0);
        skips(2);
        put(8'h02, 1'b1, 12'h001, 4'd15, 1'b0);
        skips(17);
        put(8'h7A, 1'b0, '0, '0, 1'b1);
        finish_run("R3 extreme lengths");
        chk_grp(0, 5'd3, 16'h0003, 1'b1, "R3 min and max copy");
        chk_item(0, 0, 16'h0ABC, "R2 copy length 3");
        chk_item(0, 1, 16'hF001, "R2 copy length 18");
        chk_item(0, 2, 16'h007A, "R3 literal after 17 skips");
    endtask

    task automatic t_full;
        start(1'b0);
        put(8'h00, 1'b1, 12'h111, 4'd0, 1'b0); skips(2);
        for (int i = 1; i < 15; i++) lit(8'(i));
        put(8'h00, 1'b1, 12'h222, 4'd0, 1'b0); skips(2);
        for (int i = 16; i < 19; i++) lit(8'(i));
        put(8'd19, 1'b0, '0, '0, 1'b1);
        finish_run("R4 two groups");
        chk(n_grp == 2, "R4 group count", n_grp, 2);
        chk_grp(0, 5'd16, 16'h8001, 1'b0, "R4 R2 full group LSB first");
        chk_item(0, 15, 16'h0222, "R2 item 15 slot");
        chk_item(0, 14, 16'h000E, "R4 item 14");
        chk_grp(1, 5'd4, 16'h0000, 1'b1, "R4 R5 tail group");
        chk_item(1, 0, 16'h0010, "R4 item 16 not lost");
    endtask

    task automatic t_eof_hit;
        start(1'b0);
        put(8'h5C, 1'b1, 12'h777, 4'd3, 1'b1);
        finish_run("R5 eof with hit");
        chk_grp(0, 5'd1, 16'h0000, 1'b1, "R5 eof beat is literal");
        chk_item(0, 0, 16'h005C, "R5 eof literal value");
    endtask

    task automatic t_eof_in_skip;
        start(1'b0);
        lit(8'h61);
        put(8'h62, 1'b1, 12'h345, 4'd0, 1'b0);
        skips(1);
        put(8'h64, 1'b0, '0, '0, 1'b1);
        finish_run("R5 eof inside skip");
        chk_grp(0, 5'd2, 16'h0002, 1'b1, "R5 R3 eof on covered byte");
    endtask

    task automatic t_mode;
        start(1'b1);
        put(8'hA1, 1'b1, 12'h010, 4'd5, 1'b0);
        put(8'hA2, 1'b1, 12'h020, 4'd0, 1'b0);
        put(8'hA3, 1'b0, '0, '0, 1'b1);
        finish_run("R8 literal-only run");
        chk_grp(0, 5'd3, 16'h0000, 1'b1, "R8 hits ignored");
        chk_item(0, 1, 16'h00A2, "R8 literal byte kept");
    endtask

    task automatic t_go_busy;
        start(1'b0);
        lit(8'h30);
        go = 1'b1; mode = 1'b1;
        @(negedge clk);
        go = 1'b0; mode = 1'b0;
        chk(busy == 1'b1, "R7 still busy after go", busy, 1);
        put(8'h31, 1'b1, 12'h055, 4'd0, 1'b0);
        skips(2);
        put(8'h34, 1'b0, '0, '0, 1'b1);
        finish_run("R7 go while busy");
        chk_grp(0, 5'd3, 16'h0002, 1'b1, "R7 no restart, mode kept");
        chk_item(0, 0, 16'h0030, "R7 first item kept");
        chk_item(0, 1, 16'h0055, "R7 copy still allowed");
    endtask

    task automatic t_hold;
        start(1'b0);
        out_taken = 1'b0;
        lit(8'h11);
        put(8'h12, 1'b0, '0, '0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            chk(out_valid && out_size == 5'd2 && out_last && !in_taken,
                "R9 group held while stalled", {out_valid, out_size, out_last, in_taken}, {1'b1, 5'd2, 1'b1, 1'b0});
            chk(out_items[IW +: IW] == 16'h0012, "R9 items held", out_items[IW +: IW], 16'h0012);
            @(negedge clk);
        end
        out_taken = 1'b1;
        finish_run("R9 release");
        chk(n_grp == 1, "R9 taken once", n_grp, 1);
    endtask

    initial begin
        #1;
        t_reset();
        #20;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_literals();
        t_copy();
        t_copy_extremes();
        t_full();
        t_eof_hit();
        t_eof_in_skip();
        t_mode();
        t_go_busy();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule